// File: doc/BRIEF.md
# Address Watchpoint Comparator

This block gives a debugger two programmable address traps. Each trap register holds a physical address and three enables: one for loads, one for stores and one for instruction fetches. Every cycle the pipeline presents one access (a valid strobe, three access-type flags and a physical address). When an enabled trap sees its address, the block raises an exception request on the next clock edge. The request carries a 5-bit cause code and a 2-bit field that names the trap or traps that fired.

A shared mask register widens either trap, or both, from one word to a naturally aligned power-of-two region. The mask is a run of ones that starts at address bit 2. Any ones written above the first zero are discarded, so the stored mask is always a legal range. Software programs and reads back all three registers through a simple write/read port. Address translation and exception dispatch are handled elsewhere.

Top module: `addr_watch_unit`

## Requirements
- R1: While reset is high, every trap enable and every stored field is cleared, so after reset all registers read zero and no exception is raised.
- R2: Selecting trap register 0 or 1 (cfg_sel 0 or 1) and writing keeps bit 63 (store enable), bit 62 (load enable), bit 61 (fetch enable) and bits 35:2 (address). Every other bit reads back as zero.
- R3: A write to select 2 (mask) keeps bit 0 (apply mask to trap 0) and bit 1 (apply to trap 1). Of bits 31:2 it keeps bit i only if bits 2 through i were all written as one. All other bits read as zero.
- R4: A valid load (or store) whose address equals a trap's address on all compared bits, with that trap's load (or store) enable set, gives exc_req=1 and exc_code=23 one cycle later.
- R5: A valid instruction fetch that hits a trap with its fetch enable set gives exc_req=1 and exc_code=16 one cycle later.
- R6: exc_hit bit i is set when trap i fired. If both traps fire in the same cycle, both bits are set and only one request is raised.
- R7: When one access fires a data-type trap and a fetch-type trap at the same time, exc_code is 16.
- R8: Address bits 1:0 are never compared. Bits covered by the mask are ignored, but only for traps whose apply bit is set.
- R9: No request is raised when acc_valid is low or when the access flags do not meet a set enable. A write to select 3 changes nothing, and a read of select 3 returns zero.
- R10: The read port returns the selected register one cycle after cfg_rsel is presented. When no trap fires, exc_req, exc_code and exc_hit are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Write target: 0/1 trap, 2 mask, 3 none |
| cfg_wdata | input | 64 | Write data |
| cfg_rsel | input | 2 | Read target, same encoding |
| cfg_rdata | output | 64 | Registered read data |
| acc_valid | input | 1 | Access present this cycle |
| acc_load | input | 1 | Access is a load |
| acc_store | input | 1 | Access is a store |
| acc_ifetch | input | 1 | Access is an instruction fetch |
| acc_paddr | input | 36 | Physical address of the access |
| exc_req | output | 1 | Exception request, registered |
| exc_code | output | 5 | Cause code: 23 data, 16 fetch, 0 idle |
| exc_hit | output | 2 | Which traps fired |

## Verification
The hardest case to reach is a single access that fires a data trap on one register and a fetch trap on the other in the same cycle. That case tests both the identity field and the code priority at once. The bench sets it up by giving both traps the same address with different enables, then raising load and fetch together. It then drops each flag in turn to isolate each half. The per-trap mask selection is reached by moving the apply bits while leaving the range and the address unchanged. A lone address change at bit 2 then flips the outcome.

// File: rtl/awu_pkg.sv
package awu_pkg;
  localparam logic [4:0] CODE_DATA = 5'd23;
  localparam logic [4:0] CODE_INST = 5'd16;
  localparam logic [4:0] CODE_NONE = 5'd0;
  localparam int BIT_EN_ST = 63;
  localparam int BIT_EN_LD = 62;
  localparam int BIT_EN_IF = 61;
endpackage

// File: rtl/awu_regs.sv
module awu_regs
  import awu_pkg::*;
#(
  parameter int NUM_WATCH = 2,
  parameter int PA_W      = 36,
  parameter int MASK_TOP  = 31,
  parameter int DW        = 64,
  parameter int SEL_W     = 2,
  localparam int AW       = PA_W - 2,
  localparam int MW       = MASK_TOP - 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [SEL_W-1:0]              wsel,
  input  logic [DW-1:0]                 wdata,
  input  logic [SEL_W-1:0]              rsel,
  output logic [DW-1:0]                 rdata,
  output logic [NUM_WATCH-1:0]          en_ld,
  output logic [NUM_WATCH-1:0]          en_st,
  output logic [NUM_WATCH-1:0]          en_if,
  output logic [NUM_WATCH-1:0][AW-1:0]  waddr,
  output logic [MW-1:0]                 mfield,
  output logic [NUM_WATCH-1:0]          mapply
);
  localparam int MASK_SEL = NUM_WATCH;

  logic [MW-1:0] san;
  logic [DW-1:0] rd_word;
  logic          unused_wbits;

  assign unused_wbits = ^wdata[BIT_EN_IF-1:PA_W];

  // keep only the run of ones that starts at address bit 2
  always_comb begin
    san[0] = wdata[2];
    for (int i = 1; i < MW; i++) san[i] = san[i-1] & wdata[i+2];
  end

  for (genvar g = 0; g < NUM_WATCH; g++) begin : g_trap
    always_ff @(posedge clk) begin
      if (rst) begin
        en_ld[g] <= 1'b0;
        en_st[g] <= 1'b0;
        en_if[g] <= 1'b0;
        waddr[g] <= '0;
      end else if (we && wsel == SEL_W'(g)) begin
        en_st[g] <= wdata[BIT_EN_ST];
        en_ld[g] <= wdata[BIT_EN_LD];
        en_if[g] <= wdata[BIT_EN_IF];
        waddr[g] <= wdata[PA_W-1:2];
      end
    end

    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
      (we && wsel == SEL_W'(g)) |=> (waddr[g] == $past(wdata[PA_W-1:2])
                                     && en_if[g] == $past(wdata[BIT_EN_IF])));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mfield <= '0;
      mapply <= '0;
    end else if (we && wsel == SEL_W'(MASK_SEL)) begin
      mfield <= san;
      mapply <= wdata[NUM_WATCH-1:0];
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_WATCH; i++) begin
      if (rsel == SEL_W'(i)) begin
        rd_word[BIT_EN_ST]  = en_st[i];
        rd_word[BIT_EN_LD]  = en_ld[i];
        rd_word[BIT_EN_IF]  = en_if[i];
        rd_word[PA_W-1:2]   = waddr[i];
      end
    end
    if (rsel == SEL_W'(MASK_SEL)) begin
      rd_word[MASK_TOP:2]      = mfield;
      rd_word[NUM_WATCH-1:0]   = mapply;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_word;
  end

  p_mask_contig_r3: assert property (@(posedge clk) disable iff (rst)
    ((mfield + MW'(1)) & mfield) == '0);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (en_ld == '0 && en_st == '0 && en_if == '0 && mapply == '0));
endmodule

// File: rtl/awu_match.sv
module awu_match #(
  parameter int PA_W = 36,
  parameter int MW   = 30,
  localparam int AW  = PA_W - 2
) (
  input  logic            acc_valid,
  input  logic            acc_load,
  input  logic            acc_store,
  input  logic            acc_ifetch,
  input  logic [PA_W-1:0] paddr,
  input  logic            en_ld,
  input  logic            en_st,
  input  logic            en_if,
  input  logic [AW-1:0]   waddr,
  input  logic [MW-1:0]   mfield,
  input  logic            apply,
  output logic            data_hit,
  output logic            inst_hit
);
  logic [PA_W-1:0] ignore;
  logic            addr_eq;

  // bits 1:0 always ignored; masked bits ignored when apply is set
  assign ignore  = {{(AW-MW){1'b0}}, mfield & {MW{apply}}, 2'b11};
  assign addr_eq = (((paddr ^ {waddr, 2'b00}) & ~ignore) == '0);

  assign data_hit = acc_valid && addr_eq && ((acc_load && en_ld) || (acc_store && en_st));
  assign inst_hit = acc_valid && addr_eq && acc_ifetch && en_if;

  always_comb begin
    if (!en_ld && !en_st && !en_if)
      p_off_silent_r9: assert (!data_hit && !inst_hit);
  end
endmodule

// File: rtl/awu_report.sv
module awu_report
  import awu_pkg::*;
#(
  parameter int NUM_WATCH = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_WATCH-1:0] data_hit,
  input  logic [NUM_WATCH-1:0] inst_hit,
  output logic                 exc_req,
  output logic [4:0]           exc_code,
  output logic [NUM_WATCH-1:0] exc_hit
);
  logic [NUM_WATCH-1:0] fired;
  logic                 any_inst;

  assign fired    = data_hit | inst_hit;
  assign any_inst = |inst_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_req  <= 1'b0;
      exc_code <= CODE_NONE;
      exc_hit  <= '0;
    end else begin
      exc_req  <= |fired;
      exc_hit  <= fired;
      if (any_inst)    exc_code <= CODE_INST;
      else if (|fired) exc_code <= CODE_DATA;
      else             exc_code <= CODE_NONE;
    end
  end

  p_code_legal_r7: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> (exc_code == CODE_INST || exc_code == CODE_DATA));
  p_req_has_id_r6: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> (exc_hit != '0));
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !exc_req |-> (exc_code == CODE_NONE && exc_hit == '0));
  p_inst_wins_r5: assert property (@(posedge clk) disable iff (rst)
    any_inst |=> (exc_code == CODE_INST));
endmodule

// File: rtl/addr_watch_unit.sv
module addr_watch_unit
  import awu_pkg::*;
#(
  parameter int NUM_WATCH = 2,
  parameter int PA_W      = 36,
  parameter int MASK_TOP  = 31,
  parameter int DW        = 64,
  localparam int SEL_W    = $clog2(NUM_WATCH + 2),
  localparam int AW       = PA_W - 2,
  localparam int MW       = MASK_TOP - 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [SEL_W-1:0]     cfg_sel,
  input  logic [DW-1:0]        cfg_wdata,
  input  logic [SEL_W-1:0]     cfg_rsel,
  output logic [DW-1:0]        cfg_rdata,
  input  logic                 acc_valid,
  input  logic                 acc_load,
  input  logic                 acc_store,
  input  logic                 acc_ifetch,
  input  logic [PA_W-1:0]      acc_paddr,
  output logic                 exc_req,
  output logic [4:0]           exc_code,
  output logic [NUM_WATCH-1:0] exc_hit
);
  logic [NUM_WATCH-1:0]         en_ld, en_st, en_if, mapply;
  logic [NUM_WATCH-1:0][AW-1:0] waddr;
  logic [MW-1:0]                mfield;
  logic [NUM_WATCH-1:0]         data_hit, inst_hit;

  awu_regs #(
    .NUM_WATCH(NUM_WATCH), .PA_W(PA_W), .MASK_TOP(MASK_TOP), .DW(DW), .SEL_W(SEL_W)
  ) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .wsel(cfg_sel), .wdata(cfg_wdata),
    .rsel(cfg_rsel), .rdata(cfg_rdata),
    .en_ld(en_ld), .en_st(en_st), .en_if(en_if), .waddr(waddr),
    .mfield(mfield), .mapply(mapply)
  );

  for (genvar g = 0; g < NUM_WATCH; g++) begin : g_cmp
    awu_match #(.PA_W(PA_W), .MW(MW)) u_match (
      .acc_valid(acc_valid), .acc_load(acc_load), .acc_store(acc_store),
      .acc_ifetch(acc_ifetch), .paddr(acc_paddr),
      .en_ld(en_ld[g]), .en_st(en_st[g]), .en_if(en_if[g]),
      .waddr(waddr[g]), .mfield(mfield), .apply(mapply[g]),
      .data_hit(data_hit[g]), .inst_hit(inst_hit[g])
    );
  end

  awu_report #(.NUM_WATCH(NUM_WATCH)) u_report (
    .clk(clk), .rst(rst), .data_hit(data_hit), .inst_hit(inst_hit),
    .exc_req(exc_req), .exc_code(exc_code), .exc_hit(exc_hit)
  );

  p_valid_gate_r9: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !exc_req);
  p_no_flags_r4: assert property (@(posedge clk) disable iff (rst)
    !(acc_load || acc_store || acc_ifetch) |=> !exc_req);
endmodule

// File: tb/sim_addr_watch_unit.sv
module sim_addr_watch_unit;
  typedef struct packed {
    logic        ld, st, fe;
    logic [35:0] addr;
    logic        req;
    logic [4:0]  code;
    logic [1:0]  hit;
  } vec_t;

  localparam int NV = 11;
  // traps: 0 = load|store @0x012345670, 1 = fetch @0x800001000 with 256-byte range
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b0, 1'b0, 36'h012345670, 1'b1, 5'd23, 2'b01},
    '{1'b0, 1'b1, 1'b0, 36'h012345673, 1'b1, 5'd23, 2'b01},
    '{1'b0, 1'b0, 1'b1, 36'h012345670, 1'b0, 5'd0,  2'b00},
    '{1'b1, 1'b0, 1'b0, 36'h012345674, 1'b0, 5'd0,  2'b00},
    '{1'b0, 1'b0, 1'b1, 36'h800001000, 1'b1, 5'd16, 2'b10},
    '{1'b0, 1'b0, 1'b1, 36'h8000010FF, 1'b1, 5'd16, 2'b10},
    '{1'b0, 1'b0, 1'b1, 36'h800001100, 1'b0, 5'd0,  2'b00},
    '{1'b1, 1'b0, 1'b0, 36'h800001000, 1'b0, 5'd0,  2'b00},
    '{1'b1, 1'b0, 1'b1, 36'h012345670, 1'b1, 5'd23, 2'b01},
    '{1'b0, 1'b0, 1'b0, 36'h012345670, 1'b0, 5'd0,  2'b00},
    '{1'b0, 1'b1, 1'b0, 36'h012345678, 1'b0, 5'd0,  2'b00}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0, cfg_rsel = '0;
  logic [63:0] cfg_wdata = '0, cfg_rdata;
  logic        acc_valid = 1'b0, acc_load = 1'b0, acc_store = 1'b0, acc_ifetch = 1'b0;
  logic [35:0] acc_paddr = '0;
  logic        exc_req;
  logic [4:0]  exc_code;
  logic [1:0]  exc_hit;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  addr_watch_unit u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
    .acc_load(acc_load), .acc_store(acc_store), .acc_ifetch(acc_ifetch),
    .acc_paddr(acc_paddr), .exc_req(exc_req), .exc_code(exc_code), .exc_hit(exc_hit)
  );

  task automatic wr(input logic [1:0] sel, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic chk_rd(input string req, input logic [1:0] sel, input logic [63:0] exp);
    @(negedge clk);
    cfg_rsel = sel;
    @(negedge clk);
    total++;
    if (cfg_rdata !== exp) begin
      bad++;
      $display("FAIL %s read sel=%0d got=%h exp=%h", req, sel, cfg_rdata, exp);
    end
  endtask

  task automatic chk_acc(input string req, input logic v, input logic ld, input logic st,
                         input logic fe, input logic [35:0] a, input logic er,
                         input logic [4:0] ec, input logic [1:0] eh);
    @(negedge clk);
    acc_valid = v; acc_load = ld; acc_store = st; acc_ifetch = fe; acc_paddr = a;
    @(negedge clk);
    acc_valid = 1'b0; acc_load = 1'b0; acc_store = 1'b0; acc_ifetch = 1'b0;
    total++;
    if (exc_req !== er || exc_code !== ec || exc_hit !== eh) begin
      bad++;
      $display("FAIL %s addr=%h got req=%b code=%0d hit=%b exp req=%b code=%0d hit=%b",
               req, a, exc_req, exc_code, exc_hit, er, ec, eh);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk_rd("R1", 2'd0, 64'h0);
    chk_rd("R1", 2'd2, 64'h0);
    chk_acc("R1", 1'b1, 1'b1, 1'b1, 1'b1, 36'h0, 1'b0, 5'd0, 2'b00);
    // R2: reserved bits of a trap register read zero
    wr(2'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    chk_rd("R2", 2'd0, 64'hE000_000F_FFFF_FFFC);
    // R3: mask keeps only the low run of ones
    wr(2'd2, 64'hFFFF_FFFF_0000_00F7);
    chk_rd("R3", 2'd2, 64'h0000_0000_0000_0007);
    wr(2'd2, 64'h0000_0000_FFFF_FFFE);
    chk_rd("R3", 2'd2, 64'h0000_0000_FFFF_FFFE);
    // table setup
    wr(2'd0, 64'hC000_0000_1234_5670);
    wr(2'd1, 64'h2000_0008_0000_1000);
    wr(2'd2, 64'h0000_0000_0000_00FE);
    chk_rd("R2", 2'd1, 64'h2000_0008_0000_1000);
    // R4 R5 R8 R10 vectors
    for (int i = 0; i < NV; i++)
      chk_acc("R4/R5/R8/R10 table", 1'b1, TBL[i].ld, TBL[i].st, TBL[i].fe, TBL[i].addr,
              TBL[i].req, TBL[i].code, TBL[i].hit);
    // R6 R7: both traps on one address, different types
    wr(2'd0, 64'h4000_0000_0000_2000);
    wr(2'd1, 64'h2000_0000_0000_2000);
    wr(2'd2, 64'h0);
    chk_acc("R6 R7", 1'b1, 1'b1, 1'b0, 1'b1, 36'h2000, 1'b1, 5'd16, 2'b11);
    chk_acc("R6", 1'b1, 1'b1, 1'b0, 1'b0, 36'h2000, 1'b1, 5'd23, 2'b01);
    chk_acc("R5", 1'b1, 1'b0, 1'b0, 1'b1, 36'h2000, 1'b1, 5'd16, 2'b10);
    // R9: valid low
    chk_acc("R9", 1'b0, 1'b1, 1'b0, 1'b1, 36'h2000, 1'b0, 5'd0, 2'b00);
    // R8: mask applies only to selected traps
    wr(2'd2, 64'h6);
    chk_acc("R8", 1'b1, 1'b1, 1'b0, 1'b0, 36'h2004, 1'b0, 5'd0, 2'b00);
    wr(2'd2, 64'h5);
    chk_acc("R8", 1'b1, 1'b1, 1'b0, 1'b0, 36'h2004, 1'b1, 5'd23, 2'b01);
    // R9: select 3 write ignored, read zero
    wr(2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    chk_rd("R9", 2'd0, 64'h4000_0000_0000_2000);
    chk_rd("R9", 2'd1, 64'h2000_0000_0000_2000);
    chk_rd("R9", 2'd2, 64'h5);
    chk_rd("R9", 2'd3, 64'h0);
    // R1: reset mid-run clears everything
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk_rd("R1", 2'd0, 64'h0);
    chk_acc("R1", 1'b1, 1'b1, 1'b0, 1'b1, 36'h2000, 1'b0, 5'd0, 2'b00);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule